// File: doc/BRIEF.md
# Reference Pulse Validity Monitor

This block watches a one-cycle reference pulse that should arrive about once per millisecond and decides whether the pulse train can be trusted. A cycle counter, clocked by the local interface clock, measures how far apart successive pulses are. Each measured interval is compared against a tolerance window that is centred on the nominal period. The result is a single valid flag that downstream logic, for example a clock-trim loop, can use to gate its use of the pulse.

The flag goes high only once a pulse has closed an interval that lies inside the window. It stays high while pulses keep landing inside the window. Any deviation drops it on the next edge: a pulse that comes too early, or a silence that lasts past the upper bound. Once dropped, the flag waits for a fresh qualifying interval before it rises again. The block also drives a copy of the pulse delayed by one register stage.

Both the nominal period in cycles and the tolerance in parts per million are parameters. The window bounds are computed from them when the block is elaborated.

Top module: `refp_monitor`

## Requirements
- R1: While `rst` is high on a clock edge, `pulse_valid_o` and `pulse_q_o` are 0 after that edge, and measurement is disarmed.
- R2: `pulse_q_o` equals the value `ref_pulse_i` had at the previous clock edge.
- R3: The window is [LO, HI]. LO = floor(CYCLES_PER_MS*(1e6-TOL_PPM)/1e6) and HI = ceil(CYCLES_PER_MS*(1e6+TOL_PPM)/1e6). For the defaults 2000 and 500, that gives 1999 and 2001. An interval is the number of clock edges from the edge that samples one pulse to the edge that samples the next. Both LO and HI are accepted.
- R4: A pulse sampled while measurement is disarmed (after reset, or after a timeout) only starts measurement: the flag stays 0.
- R5: A pulse that closes an interval inside the window sets `pulse_valid_o` to 1 from the edge that samples it.
- R6: A pulse that closes an interval shorter than LO clears `pulse_valid_o` at that edge. The next interval is measured from that pulse.
- R7: If HI edges pass after the last pulse with no new pulse, `pulse_valid_o` is 0 after the HI-th edge and measurement is disarmed. It is still 1 after edge HI-1 if it was 1 before.
- R8: `pulse_valid_o` stays 1 across any run of consecutive in-window intervals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pulse_i | input | 1 | Single-cycle reference pulse |
| pulse_valid_o | output | 1 | Pulse train within tolerance |
| pulse_q_o | output | 1 | Reference pulse delayed one cycle |

## Verification
The hardest case to reach from the ports is the silent timeout at exactly the upper bound. It is only visible as the flag falling on one particular edge with no input activity at all. The bench first brings the flag high with good intervals, then leaves the input idle and samples the flag after edge HI-1 and again after edge HI. This pins the drop to a single cycle. It then shows that the next pulse only restarts measurement, and that the pulse after it re-arms the flag.

// File: rtl/refp_pkg.sv
package refp_pkg;

    localparam longint PPM_SCALE = 1000000;

    // Classification of one clock cycle of input activity
    typedef enum logic [2:0] {
        EV_IDLE,   // nothing to do, keep counting
        EV_START,  // first pulse while disarmed
        EV_EARLY,  // pulse before the window opens
        EV_GOOD,   // pulse inside the window
        EV_LATE    // window closed with no pulse
    } refp_event_e;

    typedef struct packed {
        logic armed;
        logic valid;
    } refp_state_t;

    // Lower window bound, rounded down
    function automatic longint win_low(input longint n, input longint tol);
        return (n * (PPM_SCALE - tol)) / PPM_SCALE;
    endfunction

    // Upper window bound, rounded up
    function automatic longint win_high(input longint n, input longint tol);
        return (n * (PPM_SCALE + tol) + PPM_SCALE - 1) / PPM_SCALE;
    endfunction

endpackage

// File: rtl/refp_interval_ctr.sv
module refp_interval_ctr #(
    parameter int CW   = 12,
    parameter int MAXV = 2001
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_MAX = CW'(MAXV);

    // After a restart the count is 1, so a pulse k edges later reads k.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= CW'(1);
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/refp_window_cls.sv
module refp_window_cls
    import refp_pkg::*;
#(
    parameter int CW = 12,
    parameter int LO = 1999,
    parameter int HI = 2001
) (
    input  logic          pulse,
    input  logic          armed,
    input  logic [CW-1:0] cnt,
    output refp_event_e   ev
);
    localparam logic [CW-1:0] LO_C = CW'(LO);
    localparam logic [CW-1:0] HI_C = CW'(HI);

    always_comb begin
        ev = EV_IDLE;
        if (pulse) begin
            if (!armed)          ev = EV_START;
            else if (cnt < LO_C) ev = EV_EARLY;
            else                 ev = EV_GOOD;
        end else if (armed && cnt >= HI_C) begin
            ev = EV_LATE;
        end
    end
endmodule

// File: rtl/refp_flag_fsm.sv
module refp_flag_fsm
    import refp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  refp_event_e ev,
    output refp_state_t st
);
    refp_state_t st_d;

    always_comb begin
        st_d = st;
        unique case (ev)
            EV_START: st_d.armed = 1'b1;
            EV_EARLY: begin st_d.armed = 1'b1; st_d.valid = 1'b0; end
            EV_GOOD:  begin st_d.armed = 1'b1; st_d.valid = 1'b1; end
            EV_LATE:  begin st_d.armed = 1'b0; st_d.valid = 1'b0; end
            default:  st_d = st;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_d;
    end
endmodule

// File: rtl/refp_monitor.sv
module refp_monitor
    import refp_pkg::*;
#(
    parameter int CYCLES_PER_MS = 2000,
    parameter int TOL_PPM       = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_pulse_i,
    output logic pulse_valid_o,
    output logic pulse_q_o
);
    localparam int LO = int'(win_low(longint'(CYCLES_PER_MS), longint'(TOL_PPM)));
    localparam int HI = int'(win_high(longint'(CYCLES_PER_MS), longint'(TOL_PPM)));
    localparam int CW = $clog2(HI + 2);

    logic [CW-1:0] cnt_q;
    refp_event_e   ev;
    refp_state_t   st;
    logic          pulse_q;

    refp_interval_ctr #(.CW(CW), .MAXV(HI)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .restart (ev != EV_IDLE),
        .cnt     (cnt_q)
    );

    refp_window_cls #(.CW(CW), .LO(LO), .HI(HI)) u_cls (
        .pulse (ref_pulse_i),
        .armed (st.armed),
        .cnt   (cnt_q),
        .ev    (ev)
    );

    refp_flag_fsm u_fsm (
        .clk (clk),
        .rst (rst),
        .ev  (ev),
        .st  (st)
    );

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= ref_pulse_i;
    end

    assign pulse_valid_o = st.valid;
    assign pulse_q_o     = pulse_q;
endmodule

// File: rtl/refp_monitor_chk.sv
module refp_monitor_chk #(
    parameter int CW = 12,
    parameter int LO = 1999,
    parameter int HI = 2001
) (
    input logic          clk,
    input logic          rst,
    input logic          ref_pulse_i,
    input logic          pulse_valid_o,
    input logic          pulse_q_o,
    input logic          armed,
    input logic [CW-1:0] cnt
);
    logic live = 1'b0;
    always_ff @(posedge clk) live <= !rst;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!pulse_valid_o && !pulse_q_o && !armed));

    assert_pulse_copy_R2: assert property (@(posedge clk) disable iff (rst)
        live |-> (pulse_q_o == $past(ref_pulse_i)));

    assert_start_only_R4: assert property (@(posedge clk) disable iff (rst)
        (!armed && ref_pulse_i) |=> (!pulse_valid_o && armed));

    assert_rise_needs_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (live && $rose(pulse_valid_o)) |-> $past(ref_pulse_i));

    assert_early_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (armed && ref_pulse_i && cnt < CW'(LO)) |=> !pulse_valid_o);

    assert_late_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (armed && !ref_pulse_i && cnt >= CW'(HI)) |=> (!pulse_valid_o && !armed));

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        armed |-> (cnt <= CW'(HI)));
endmodule

bind refp_monitor refp_monitor_chk #(.CW(CW), .LO(LO), .HI(HI)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ref_pulse_i   (ref_pulse_i),
    .pulse_valid_o (pulse_valid_o),
    .pulse_q_o     (pulse_q_o),
    .armed         (st.armed),
    .cnt           (cnt_q)
);

// File: tb/tb_refp_monitor.sv
module tb_refp_monitor;
    localparam int LO = 1999;  // R3 bounds for 2000 cycles at 500 ppm
    localparam int HI = 2001;
    localparam int NV = 10;
    // gap in edges, expected flag after the pulse, requirement number
    localparam int GAP[NV] = '{5, 2000, 1999, 2001, 2000, 1998, 2000, 1000, 1000, 2000};
    localparam bit EXP[NV] = '{0, 1,    1,    1,    1,    0,    1,    0,    0,    1};
    localparam int REQ[NV] = '{4, 5,    3,    3,    8,    6,    6,    6,    6,    5};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic valid, pq;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    refp_monitor #(.CYCLES_PER_MS(2000), .TOL_PPM(500)) dut (
        .clk           (clk),
        .rst           (rst),
        .ref_pulse_i   (ref_in),
        .pulse_valid_o (valid),
        .pulse_q_o     (pq)
    );

    task automatic check(input string req, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // Pulse sampled exactly gap edges after the previous pulse edge
    task automatic send(input int gap);
        for (int j = 0; j < gap - 1; j++) begin
            @(negedge clk); ref_in = 1'b0;
        end
        @(negedge clk); ref_in = 1'b1;
        @(posedge clk); #1; ref_in = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", valid, 1'b0);
        check("R1", pq, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            send(GAP[i]);
            check($sformatf("R%0d", REQ[i]), valid, EXP[i]);
        end

        // R7: silent timeout at exactly HI edges
        repeat (HI - 1) @(posedge clk);
        #1 check("R7", valid, 1'b1);
        @(posedge clk); #1 check("R7", valid, 1'b0);
        send(2000); check("R4", valid, 1'b0);  // restart only
        send(2000); check("R5", valid, 1'b1);

        // R2: delayed copy of the pulse
        send(2000);
        check("R2", pq, 1'b1);
        check("R8", valid, 1'b1);
        @(posedge clk); #1 check("R2", pq, 1'b0);

        // R1: reset mid-run clears the flag and disarms
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R1", valid, 1'b0);
        check("R1", pq, 1'b0);
        @(negedge clk); rst = 1'b0;
        send(3);    check("R4", valid, 1'b0);
        send(2000); check("R5", valid, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule